// File: doc/BRIEF.md
# Two-Share Secret Holder with Randomised Scrub

This block keeps one secret as two masked shares, each at least 32 bits wide, and erases them on command. A load pulse captures both shares at once. When a wipe is requested, or when the anomaly input fires, the block overwrites both share registers with pseudo-random data for a fixed number of cycles. It then waits a further 0 to 15 cycles, a count drawn from an LFSR. At no point does it write zero, so a power trace never shows the secret's Hamming weight collapsing.

Each share has its own 32-bit Galois LFSR with its own seed. A third seeded LFSR supplies the random delay. The shares are driven out unchanged to the consuming logic, which recombines them. The block never combines the shares, and it has no source of true entropy.

The controller has four named states. `ST_IDLE` holds the shares and accepts loads. `ST_SCRUB` runs the fixed overwrite phase. `ST_STALL` runs the random extra overwrite cycles. `ST_DONE` raises the one-cycle done pulse. The transitions are:

- `ST_IDLE` goes to `ST_SCRUB` on a wipe or an anomaly.
- `ST_SCRUB` goes to `ST_STALL` when the fixed count ends and the drawn delay is non-zero.
- `ST_SCRUB` goes to `ST_DONE` when the fixed count ends and the drawn delay is zero.
- `ST_STALL` goes to `ST_DONE` when its count ends.
- `ST_DONE` goes back to `ST_IDLE`, or goes to `ST_SCRUB` if another trigger is present.

Top module: `share_vault`

## Requirements
- R1: A load while idle (busy low, no trigger in the same cycle) makes both share outputs equal to the share inputs from the cycle after the load.
- R2: A load while busy is high, or in the same cycle as a wipe or anomaly trigger, has no effect on the shares.
- R3: From the second busy cycle through the done cycle, both shares hold LFSR output and are never zero. Each LFSR steps right-shift Galois style with polynomial x^32+x^22+x^2+x+1: when bit 0 is 1, the next state is (s>>1) XOR 0x80200003, otherwise it is s>>1. A zero state reloads the seed.
- R4: During and after a wipe, share A and share B never hold equal values. Each share is fed by its own LFSR, and the seeds differ.
- R5: Busy stays high for exactly 4 + d cycles. The value d is bits [3:0] of the delay LFSR state at the moment the wipe starts. That LFSR starts from its own seed and advances one step at each wipe start.
- R6: The sequence of wipe durations depends only on how many wipes have run, never on the stored share values.
- R7: Done is high for exactly one cycle, the cycle right after the last busy cycle.
- R8: An anomaly starts a wipe exactly as a wipe request does. From the next cycle on, the alert output is high and stays high until reset.
- R9: A wipe request never raises the alert. A request or anomaly that arrives while busy is high neither restarts nor lengthens the wipe.
- R10: After reset, both shares are zero, and busy, done and alert are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture both share inputs |
| share_a_i | input | SHARE_W | Share A to store |
| share_b_i | input | SHARE_W | Share B to store |
| wipe_i | input | 1 | Request a scrub of both shares |
| anomaly_i | input | 1 | Anomaly seen elsewhere; scrub and alert |
| share_a_o | output | SHARE_W | Stored share A |
| share_b_o | output | SHARE_W | Stored share B |
| busy_o | output | 1 | Scrub in progress |
| done_o | output | 1 | One-cycle pulse when a scrub ends |
| alert_o | output | 1 | Sticky alert after an anomaly |

## Verification
A corrupted controller count or a wrong delay draw shows on busy_o as a wipe that is one or more cycles too long or too short. It also shifts where the done pulse falls, so the error is visible at the end of that same wipe. A broken share LFSR or a shared seed shows on the share outputs as a zero share or as two equal shares, one cycle after the first busy cycle. A wrong delay LFSR step does not show on the wipe in progress; it makes the next wipe's duration differ from the value expected from the polynomial.

// File: rtl/share_vault_pkg.sv
package share_vault_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SCRUB = 2'b01,
        ST_STALL = 2'b11,
        ST_DONE  = 2'b10
    } vault_state_e;

    localparam logic [31:0] POLY32 = 32'h8020_0003;

endpackage

// File: rtl/sv_galois_lfsr.sv
module sv_galois_lfsr #(
    parameter int           W    = 32,
    parameter logic [W-1:0] POLY = W'(share_vault_pkg::POLY32),
    parameter logic [W-1:0] SEED = W'(1)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] next_s;

    always_comb begin
        if (state_q[0]) begin
            next_s = (state_q >> 1) ^ POLY;
        end else begin
            next_s = state_q >> 1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SEED;
        end else if (step_i) begin
            if (next_s == '0) begin
                state_q <= SEED;
            end else begin
                state_q <= next_s;
            end
        end
    end

    assign state_o = state_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != '0); // R3

    AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(state_q)); // R6

endmodule

// File: rtl/sv_wipe_ctrl.sv
module sv_wipe_ctrl
    import share_vault_pkg::*;
#(
    parameter int FIX_CYC  = 4,
    parameter int DLY_BITS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wipe_i,
    input  logic                anomaly_i,
    input  logic [DLY_BITS-1:0] delay_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                start_o,
    output logic                alert_o
);
    localparam int MAX_RUN = FIX_CYC + (1 << DLY_BITS) - 1;
    localparam int CNT_MAX = (FIX_CYC > (1 << DLY_BITS)) ? FIX_CYC : (1 << DLY_BITS);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    vault_state_e        state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [DLY_BITS-1:0] dly_q, dly_d;
    logic                alert_q;
    logic                trigger;

    assign trigger = wipe_i | anomaly_i;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dly_q   <= '0;
            alert_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dly_q   <= dly_d;
            alert_q <= alert_q | anomaly_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        dly_d   = dly_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trigger) begin
                    state_d = ST_SCRUB;
                    cnt_d   = CNT_W'(FIX_CYC - 1);
                    dly_d   = delay_i;
                end
            end
            ST_SCRUB: begin
                if (cnt_q == '0) begin
                    if (dly_q == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_STALL;
                        cnt_d   = CNT_W'(dly_q) - CNT_W'(1);
                    end
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_STALL: begin
                if (cnt_q == '0) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_DONE: begin
                if (trigger) begin
                    state_d = ST_SCRUB;
                    cnt_d   = CNT_W'(FIX_CYC - 1);
                    dly_d   = delay_i;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_SCRUB;
                cnt_d   = CNT_W'(FIX_CYC - 1);
            end
        endcase
    end

    // outputs
    always_comb begin
        busy_o  = 1'b0;
        done_o  = 1'b0;
        start_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_o = trigger;
            ST_SCRUB: busy_o  = 1'b1;
            ST_STALL: busy_o  = 1'b1;
            ST_DONE: begin
                done_o  = 1'b1;
                start_o = trigger;
            end
            default:  busy_o  = 1'b1;
        endcase
    end

    assign alert_o = alert_q;

    logic [CNT_W:0] run_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + (CNT_W + 1)'(1);
        end else begin
            run_q <= '0;
        end
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (int'(run_q) < MAX_RUN)); // R5
    AST_BUSY_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (int'(run_q) >= FIX_CYC)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(busy_o)); // R7
    AST_ALERT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_o |=> alert_o); // R8
    AST_ANOMALY_ALERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        anomaly_i |=> alert_o); // R8
    AST_ANOMALY_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (anomaly_i && !busy_o) |=> busy_o); // R8
    AST_WIPE_NO_ALERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!alert_o && !anomaly_i) |=> !alert_o); // R9

endmodule

// File: rtl/share_vault.sv
module share_vault #(
    parameter int                  SHARE_W  = 32,
    parameter int                  FIX_CYC  = 4,
    parameter int                  DLY_BITS = 4,
    parameter logic [SHARE_W-1:0]  POLY     = SHARE_W'(share_vault_pkg::POLY32),
    parameter logic [SHARE_W-1:0]  SEED_A   = SHARE_W'(32'h1234_5678),
    parameter logic [SHARE_W-1:0]  SEED_B   = SHARE_W'(32'h0BAD_5EED),
    parameter logic [SHARE_W-1:0]  SEED_D   = SHARE_W'(32'h7A3C_91E5)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [SHARE_W-1:0] share_a_i,
    input  logic [SHARE_W-1:0] share_b_i,
    input  logic               wipe_i,
    input  logic               anomaly_i,
    output logic [SHARE_W-1:0] share_a_o,
    output logic [SHARE_W-1:0] share_b_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               alert_o
);
    localparam int NUM_SH = 2;
    localparam logic [SHARE_W-1:0] SEEDS [NUM_SH] = '{SEED_A, SEED_B};

    initial begin
        assert (SHARE_W >= 32 && DLY_BITS <= SHARE_W && FIX_CYC >= 1 && SEED_A != SEED_B)
            else $error("share_vault: illegal parameters");
    end

    logic                busy, start;
    logic [SHARE_W-1:0]  dly_state;
    logic [SHARE_W-1:0]  lfsr_val [NUM_SH];
    logic [SHARE_W-1:0]  share_q  [NUM_SH];
    logic [SHARE_W-1:0]  share_in [NUM_SH];

    assign share_in[0] = share_a_i;
    assign share_in[1] = share_b_i;

    sv_galois_lfsr #(.W(SHARE_W), .POLY(POLY), .SEED(SEED_D)) i_dly_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (start),
        .state_o (dly_state)
    );

    sv_wipe_ctrl #(.FIX_CYC(FIX_CYC), .DLY_BITS(DLY_BITS)) i_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wipe_i    (wipe_i),
        .anomaly_i (anomaly_i),
        .delay_i   (dly_state[DLY_BITS-1:0]),
        .busy_o    (busy),
        .done_o    (done_o),
        .start_o   (start),
        .alert_o   (alert_o)
    );

    for (genvar s = 0; s < NUM_SH; s++) begin : g_share
        sv_galois_lfsr #(.W(SHARE_W), .POLY(POLY), .SEED(SEEDS[s])) i_lfsr (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .step_i  (busy),
            .state_o (lfsr_val[s])
        );

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                share_q[s] <= '0;
            end else if (busy) begin
                share_q[s] <= lfsr_val[s];
            end else if (load_i && !start) begin
                share_q[s] <= share_in[s];
            end
        end
    end

    assign share_a_o = share_q[0];
    assign share_b_o = share_q[1];
    assign busy_o    = busy;

    AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !busy && !wipe_i && !anomaly_i) |=>
        (share_a_o == $past(share_a_i) && share_b_o == $past(share_b_i))); // R1
    AST_SCRUB_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(busy) |-> (share_a_o != '0 && share_b_o != '0)); // R3
    AST_SHARES_DIFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(busy) |-> (share_a_o != share_b_o)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && !load_i) |=> ($stable(share_a_o) && $stable(share_b_o))); // R2

endmodule

// File: tb/test_share_vault.sv
module test_share_vault;
    localparam int          W      = 32;
    localparam logic [31:0] PLY    = 32'h8020_0003;
    localparam logic [31:0] SD_A   = 32'h1234_5678;
    localparam logic [31:0] SD_B   = 32'h0BAD_5EED;
    localparam logic [31:0] SD_D   = 32'h7A3C_91E5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0, wipe = 1'b0, anom = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic [W-1:0] out_a, out_b;
    logic busy, done, alert;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] dly_model = SD_D;

    always #5 clk = ~clk;

    share_vault #(.SHARE_W(W), .SEED_A(SD_A), .SEED_B(SD_B), .SEED_D(SD_D)) i_share_vault (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .share_a_i(in_a), .share_b_i(in_b),
        .wipe_i(wipe), .anomaly_i(anom), .share_a_o(out_a), .share_b_o(out_b),
        .busy_o(busy), .done_o(done), .alert_o(alert)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] n;
        n = s[0] ? ((s >> 1) ^ PLY) : (s >> 1);
        return (n == 0) ? SD_D : n;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one wipe, started by request or anomaly; stray load/retrigger injected while busy
    task automatic do_wipe(input bit by_anom, input logic [W-1:0] old_a, input logic [W-1:0] old_b);
        int cnt;
        int exp_len;
        logic [W-1:0] stray;
        stray = old_a ^ 32'h5A5A_0F0F;
        exp_len = 4 + int'(dly_model[3:0]);
        dly_model = step(dly_model);
        @(negedge clk);
        if (by_anom) anom = 1'b1; else wipe = 1'b1;
        load = 1'b1; in_a = stray; in_b = stray;
        @(negedge clk);
        anom = 1'b0; wipe = 1'b0; load = 1'b0;
        if (by_anom) check(alert == 1'b1, "R8 alert", alert, 1);
        else check(alert == 1'b0 || by_anom, "R9 no alert", alert, 0);
        cnt = 0;
        while (busy && cnt < 40) begin
            cnt++;
            if (cnt >= 2) begin
                check(out_a != 0 && out_b != 0, "R3 nonzero", out_a, 1);
                check(out_a != out_b, "R4 distinct", out_a, out_b);
            end
            load = (cnt == 1); in_a = stray; in_b = stray;
            wipe = (cnt == 2);
            @(negedge clk);
            load = 1'b0; wipe = 1'b0;
        end
        check(cnt == exp_len, "R5/R6 busy length", cnt, exp_len);
        check(done == 1'b1, "R7 done", done, 1);
        check(out_a != old_a && out_b != old_b, "R3 overwritten", out_a, old_a);
        check(out_a != stray && out_b != stray, "R2 load ignored", out_a, stray);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R7/R9 single pulse", {done, busy}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(out_a == 0 && out_b == 0 && !busy && !done && !alert, "R10 reset",
              {busy, done, alert}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] a, b;
            if (i == 0) begin a = '0; b = '0; end
            else if (i == 1) begin a = '1; b = '1; end
            else begin a = 32'h9E37_79B9 * i; b = ~a ^ (i << 4); end
            @(negedge clk);
            load = 1'b1; in_a = a; in_b = b;
            @(negedge clk);
            load = 1'b0;
            check(out_a == a && out_b == b, "R1 load", out_a, a);
            @(negedge clk);
            check(out_a == a && out_b == b, "R1 hold", out_b, b);
            do_wipe(i >= 20, a, b);
            if (i >= 20) check(alert == 1'b1, "R8 sticky", alert, 1);
            else check(alert == 1'b0, "R9 no alert", alert, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule